// File: doc/BRIEF.md
# Oversampled Serial Character Transmitter

This block sends characters on a single asynchronous serial line. Characters enter through a write port into a small first-in first-out store. Whenever the line is free and a character is waiting, the transmitter takes it from the store and builds the complete frame in a shift register. It then shifts the frame out one bit at a time, least significant bit first. The frame is a low start bit, the data bits, an optional parity bit and one or two high stop bits.

Bit timing comes from two cascaded counters. A prescaler turns the system clock into a sample tick every (prescale + 1) clocks. A second counter takes (16 + oversample) sample ticks to make one bit. Both counters are cleared while the line is idle and start from zero on the cycle a frame is loaded, so the start bit has exactly the same width as every other bit. When the store holds another character at the end of a frame's last stop bit, the next start bit follows in the very next clock with no idle gap.

Configuration inputs are levels. They are expected to change only while the transmitter is idle and the store is empty.

Top module: `serial_tx`

## Requirements
- R1: After reset the line `tx` is high, `busy` is low, `empty` is high and `full` is low; `tx` is high whenever `busy` is low.
- R2: Every bit, the start bit included, lasts exactly (cfg_prescale + 1) × (16 + cfg_ovs) clock cycles, for example 20 × 25 = 500 clocks with cfg_prescale = 19 and cfg_ovs = 9.
- R3: With cfg_nine = 0 a frame carries wr_data[7:0], least significant bit first, right after a low start bit; wr_data[8] is not sent and does not enter the parity.
- R4: With cfg_nine = 1 a frame carries all nine bits wr_data[8:0], least significant bit first, and parity is taken over all nine.
- R5: cfg_fmt = 2'b00 ends the frame with one high stop bit, and cfg_fmt = 2'b01 ends it with two high stop bits; neither of these formats has a parity bit.
- R6: cfg_fmt = 2'b10 inserts after the data an even-parity bit that makes the count of ones in data plus parity even; cfg_fmt = 2'b11 inserts an odd-parity bit, which makes that count odd. One high stop bit follows in both cases.
- R7: Characters are sent in write order, and the store holds up to 8 of them. When a character is waiting as the last stop bit ends, the next start bit begins on the next clock cycle.
- R8: `full` is high while 8 characters are waiting. A write while `full` is high is dropped and is never transmitted.
- R9: `busy` is high from the first cycle of the start bit through the last cycle of the final stop bit, and `empty` is high exactly when no character is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prescale | input | 8 | Sample tick divider minus one |
| cfg_ovs | input | 4 | Sample ticks per bit minus 16 |
| cfg_nine | input | 1 | 0: eight data bits, 1: nine data bits |
| cfg_fmt | input | 2 | 00 one stop, 01 two stops, 10 even parity, 11 odd parity |
| wr_en | input | 1 | Write strobe for the character store |
| wr_data | input | 9 | Character to send |
| tx | output | 1 | Serial output line, idles high |
| busy | output | 1 | A frame is on the line |
| empty | output | 1 | No character waiting |
| full | output | 1 | Character store holds 8 entries |

## Verification
Two functions can fall in the same cycle. A write into the store can land on the same edge on which the transmitter pops a character, and the end of one frame's last stop bit can coincide with loading the next character. The bench provokes both by writing ten characters on ten back-to-back cycles while the line is idle. The first write is popped on the edge that takes the second write. The remaining writes then fill the store to 8, and the tenth write must be dropped. The scoreboard judges the result: exactly nine frames must arrive in write order, and each later frame's start bit must appear on the cycle right after the previous stop bit.

// File: rtl/stx_pkg.sv
package stx_pkg;
    localparam int DATA_W  = 9;
    localparam int FRAME_W = DATA_W + 3;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic wr_ok, rd_ok;

    always_comb begin
        s_d   = s_q;
        wr_ok = wr_en && (s_q.cnt != CW'(DEPTH));
        rd_ok = rd_en && (s_q.cnt != '0);
        if (wr_ok) begin
            s_d.mem[s_q.wp] = wr_data;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (rd_ok) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({wr_ok, rd_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.mem[s_q.rp];
    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(s_q.cnt));
endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
    parameter int PRE_W = 8,
    parameter int OVS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic [OVS_W-1:0] cfg_ovs,
    output logic             bit_end
);
    localparam int SMP_W = OVS_W + 1;
    localparam int BASE  = 2 ** OVS_W;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SMP_W-1:0] smp;
    } baud_st_t;

    baud_st_t s_d, s_q;
    logic [SMP_W-1:0] smp_last;
    logic             tick;

    always_comb begin
        smp_last = SMP_W'(BASE - 1) + {1'b0, cfg_ovs};
        tick     = (s_q.pre == cfg_pre);
        s_d      = s_q;
        if (!run) begin
            s_d.pre = '0;
            s_d.smp = '0;
        end else if (tick) begin
            s_d.pre = '0;
            s_d.smp = (s_q.smp == smp_last) ? '0 : s_q.smp + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_end = run && tick && (s_q.smp == smp_last);

    assert_sample_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.smp <= smp_last));
    assert_idle_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.pre == '0 && s_q.smp == '0));
endmodule

// File: rtl/stx_framer.sv
module stx_framer
    import stx_pkg::*;
(
    input  logic [DATA_W-1:0]  data,
    input  logic               nine,
    input  logic [1:0]         fmt,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   len
);
    logic [DATA_W-1:0] mask;
    logic              par;

    always_comb begin
        mask  = nine ? '1 : {1'b0, {(DATA_W-1){1'b1}}};
        par   = (^(data & mask)) ^ fmt[0];
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (mask[i]) frame[1+i] = data[i];
        end
        if (fmt[1]) begin
            if (nine) frame[1+DATA_W] = par;
            else      frame[DATA_W]   = par;
        end
        len = LEN_W'(DATA_W + 2) - {{(LEN_W-1){1'b0}}, !nine}
                                 + {{(LEN_W-1){1'b0}}, (fmt != 2'b00)};
    end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import stx_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int OVS_W = 4,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [OVS_W-1:0]  cfg_ovs,
    input  logic              cfg_nine,
    input  logic [1:0]        cfg_fmt,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx,
    output logic              busy,
    output logic              empty,
    output logic              full
);
    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sreg;
        logic [LEN_W-1:0]   left;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic [DATA_W-1:0]  head;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   len;
    logic               pop, bit_end, fifo_empty, fifo_full;

    stx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head), .empty(fifo_empty), .full(fifo_full)
    );

    stx_baud #(.PRE_W(PRE_W), .OVS_W(OVS_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(s_q.busy), .cfg_pre(cfg_prescale),
        .cfg_ovs(cfg_ovs), .bit_end(bit_end)
    );

    stx_framer u_framer (
        .data(head), .nine(cfg_nine), .fmt(cfg_fmt), .frame(frame), .len(len)
    );

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        if (s_q.busy && bit_end) begin
            if (s_q.left == LEN_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.sreg = '1;
                s_d.left = '0;
            end else begin
                s_d.sreg = {1'b1, s_q.sreg[FRAME_W-1:1]};
                s_d.left = s_q.left - 1'b1;
            end
        end
        if (!fifo_empty && (!s_q.busy || (bit_end && s_q.left == LEN_W'(1)))) begin
            pop      = 1'b1;
            s_d.busy = 1'b1;
            s_d.sreg = frame;
            s_d.left = len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy <= 1'b0;
            s_q.sreg <= '1;
            s_q.left <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx    = s_q.sreg[0];
    assign busy  = s_q.busy;
    assign empty = fifo_empty;
    assign full  = fifo_full;

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);
    assert_bits_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.left != '0));
endmodule

// File: tb/serial_tx_test.sv
module serial_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_prescale = '0;
    logic [3:0] cfg_ovs = '0;
    logic       cfg_nine = 1'b0;
    logic [1:0] cfg_fmt = '0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx, busy, empty, full;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_end = 0;

    typedef struct {
        logic [11:0] bits;
        int          len;
        int          n;
        bit          b2b;
        string       tag;
    } exp_t;
    exp_t q[$];

    serial_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_ovs(cfg_ovs),
        .cfg_nine(cfg_nine), .cfg_fmt(cfg_fmt), .wr_en(wr_en), .wr_data(wr_data),
        .tx(tx), .busy(busy), .empty(empty), .full(full)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic exp_t build(input logic [8:0] d, input string tag, input bit b2b);
        exp_t e;
        int   db, ones;
        db = cfg_nine ? 9 : 8;
        ones = 0;
        e.bits = '1;
        e.bits[0] = 1'b0;
        for (int i = 0; i < db; i++) begin
            e.bits[1+i] = d[i];
            ones += int'(d[i]);
        end
        if (cfg_fmt[1]) e.bits[1+db] = cfg_fmt[0] ? ((ones % 2) == 0) : ((ones % 2) == 1);
        e.len = 1 + db + 1 + ((cfg_fmt != 2'b00) ? 1 : 0);
        e.n   = (int'(cfg_prescale) + 1) * (16 + int'(cfg_ovs));
        e.b2b = b2b;
        e.tag = tag;
        return e;
    endfunction

    task automatic put(input logic [8:0] d, input string tag, input bit b2b);
        q.push_back(build(d, tag, b2b));
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || busy || !empty);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: checks every bit on its first and last cycle, and busy throughout
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx === 1'b0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected frame", 1, 0);
                end else begin
                    exp_t e;
                    int bad, bk, av, ev;
                    e = q.pop_front();
                    bad = 0; bk = -1; av = 0; ev = 0;
                    if (e.b2b) chk(cyc == last_end + 1, "R7", "gap before frame",
                                   cyc - last_end - 1, 0);
                    for (int t = 0; t < e.len * e.n; t++) begin
                        if (t > 0) @(negedge clk);
                        if (busy !== 1'b1) begin
                            bad++;
                            if (bk < 0) begin bk = t / e.n; av = 2; ev = 1; end
                        end
                        if ((t % e.n == 0) || (t % e.n == e.n - 1)) begin
                            if (tx !== e.bits[t / e.n]) begin
                                bad++;
                                if (bk < 0) begin
                                    bk = t / e.n; av = int'(tx); ev = int'(e.bits[t / e.n]);
                                end
                            end
                        end
                    end
                    last_end = cyc;
                    chk(bad == 0, e.tag, $sformatf("frame bit %0d (R2/R9 timing)", bk), av, ev);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx == 1'b1, "R1", "tx after reset", int'(tx), 1);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
        chk(full == 1'b0, "R1", "full after reset", int'(full), 0);

        // 8-bit, one stop, 16 clocks per bit
        put(9'h0A5, "R3", 0); wait_idle();
        put(9'h001, "R5", 0); wait_idle();
        cfg_fmt = 2'b01; put(9'h03C, "R5", 0); wait_idle();
        cfg_fmt = 2'b10; put(9'h007, "R6", 0); wait_idle();
        put(9'h00F, "R6", 0); wait_idle();
        cfg_fmt = 2'b11; put(9'h007, "R6", 0); wait_idle();
        put(9'h00F, "R6", 0); wait_idle();
        // bit 8 ignored in 8-bit mode, also for parity
        cfg_fmt = 2'b10; put(9'h180, "R3", 0); wait_idle();
        // nine data bits
        cfg_nine = 1'b1; cfg_fmt = 2'b00; put(9'h155, "R4", 0); wait_idle();
        cfg_fmt = 2'b10; put(9'h100, "R4", 0); wait_idle();
        cfg_fmt = 2'b11; put(9'h1FF, "R4", 0); wait_idle();
        // other bit periods
        cfg_nine = 1'b0; cfg_fmt = 2'b00;
        cfg_prescale = 8'd2;  cfg_ovs = 4'd3;  put(9'h05A, "R2", 0); wait_idle();
        cfg_prescale = 8'd0;  cfg_ovs = 4'd15; put(9'h033, "R2", 0); wait_idle();
        cfg_prescale = 8'd19; cfg_ovs = 4'd9;  put(9'h0C3, "R2", 0); wait_idle();

        // burst: concurrent write and pop, fill to full, drop the tenth
        cfg_prescale = 8'd0; cfg_ovs = 4'd0;
        for (int i = 0; i < 9; i++) put(9'(8'h10 + i), "R7", i > 0);
        chk(full == 1'b1, "R8", "full after 8 waiting", int'(full), 1);
        chk(empty == 1'b0, "R9", "empty while waiting", int'(empty), 0);
        wr_en = 1'b1; wr_data = 9'h0EE;
        @(negedge clk);
        wr_en = 1'b0;
        chk(full == 1'b1, "R8", "full after dropped write", int'(full), 1);
        wait_idle();
        repeat (40) @(negedge clk);
        chk(q.size() == 0, "R8", "frames left", q.size(), 0);
        chk(tx == 1'b1, "R1", "tx idle at end", int'(tx), 1);
        chk(empty == 1'b1 && full == 1'b0, "R9", "flags at end",
            int'({empty, full}), 2);
        finish_up();
    end
endmodule